// File: doc/BRIEF.md
# Block-Transfer DMA Engine for Block Storage

This engine moves one whole storage block between a block-storage word stream and main memory, so the CPU does not copy the data itself. Software writes the block number and the starting memory address into two registers. It then writes a command word to the control register. That write is the doorbell: no other access is needed to start. While the transfer runs, software polls the ready bit in the status register. The bit is low for the whole transfer and returns high once the last of the 256 sixteen-bit words has moved.

The engine has three ports. The CPU register port is a single-cycle select/write-enable slave with combinational read data. The memory master port drives an enable, a write enable, an address and write data; read data returns one cycle after a read is issued. The storage port has a one-cycle start pulse that carries the block number and the direction. It also has two word streams, one from storage and one to storage, each with valid/ready handshaking.

The controller is a state machine with six states:
- `ST_IDLE` waits for the doorbell. On a valid command it takes `IDLE->ARM`.
- `ST_ARM` pulses the start signal to storage. It takes `ARM->RD_MOVE` for a read or `ARM->WR_FETCH` for a write.
- `ST_RD_MOVE` writes each accepted storage word to memory. On the final word it takes `RD_MOVE->IDLE`.
- `ST_WR_FETCH` issues a memory read and always takes `WR_FETCH->WR_LATCH`.
- `ST_WR_LATCH` captures the returned word and always takes `WR_LATCH->WR_SEND`.
- `ST_WR_SEND` offers the word to storage. When the word is accepted it takes `WR_SEND->WR_FETCH`, or `WR_SEND->IDLE` if it was the final word.

Top module: `blkdma_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, status reads 16'h8000 (ready bit 15 set, all other bits 0). While idle, `mem_en` and `sto_start` stay low.
- R2: Register offsets on `cpu_addr` are: 0 status, 1 control, 2 block number, 3 memory start address. Offsets 2 and 3 read back the last value written to them; both reset to 0. Control always reads 0.
- R3: Writing 1 to control while idle starts a read. In the cycle after the write, `sto_start` is high for exactly one cycle, with `sto_dir`=0 and `sto_blk` equal to the block number. From that cycle on, the ready bit reads 0.
- R4: A read transfer accepts exactly 256 words from the storage input stream. Word i is written to memory address start+i, in arrival order, in the same cycle as its handshake.
- R5: Writing 2 to control while idle starts a write, with `sto_dir`=1 on the start pulse. Word i presented on the storage output stream is the memory content at start+i.
- R6: The ready bit stays 0 until the final word's handshake. It reads 1 from the cycle after that handshake.
- R7: A control write of any value other than 1 or 2 has no effect. A control write of any value while a transfer is in progress is ignored.
- R8: Memory addresses step by one per word and wrap from 16'hFFFF to 16'h0000.
- R9: The block number and start address are captured at the doorbell. Rewriting either register during a transfer changes the value read back but not the transfer in progress.
- R10: During a read, memory is written only in cycles where the storage input is valid. During a write, a word offered with `sto_out_ready` low stays valid and unchanged in the next cycle.
- R11: During a write, data is taken from `mem_rdata` one cycle after a read with `mem_we` low. The engine never asserts `mem_we` in a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Register access strobe |
| cpu_we | input | 1 | Register write when high, read when low |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 16 | Register write data |
| cpu_rdata | output | 16 | Register read data (combinational) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after a read |
| sto_start | output | 1 | One-cycle transfer start to storage |
| sto_dir | output | 1 | 0 storage to memory, 1 memory to storage |
| sto_blk | output | 16 | Block number for the transfer |
| sto_in_valid | input | 1 | Storage word available |
| sto_in_ready | output | 1 | Engine accepts a storage word |
| sto_in_data | input | 16 | Word from storage |
| sto_out_valid | output | 1 | Word offered to storage |
| sto_out_ready | input | 1 | Storage accepts the word |
| sto_out_data | output | 16 | Word to storage |

## Verification
The assertions check on every cycle the following:
- a doorbell always raises busy and the start pulse;
- a launch never happens while busy;
- the final handshake always returns the engine to idle;
- memory is never touched while idle;
- a stalled outgoing word stays stable.

The following can only be shown by the bench's scenarios:
- the data ordering and address arithmetic, including wrap past 16'hFFFF;
- the capture of block number and address at the doorbell despite later rewrites;
- the ignoring of invalid or mid-transfer commands;
- the exact cycle in which the ready bit falls and returns.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RD_MOVE,
        ST_WR_FETCH,
        ST_WR_LATCH,
        ST_WR_SEND
    } dma_state_e;

    localparam int RA_W = 2;
    localparam logic [RA_W-1:0] REG_STATUS = 2'd0;
    localparam logic [RA_W-1:0] REG_CTRL   = 2'd1;
    localparam logic [RA_W-1:0] REG_BLOCK  = 2'd2;
    localparam logic [RA_W-1:0] REG_MADDR  = 2'd3;

    localparam int CMD_READ  = 1;
    localparam int CMD_WRITE = 2;
    localparam int READY_BIT = 15;

endpackage

// File: rtl/blkdma_regs.sv
module blkdma_regs
    import blkdma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [RA_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              busy,
    output logic [BLK_W-1:0]  blk_o,
    output logic [ADDR_W-1:0] maddr_o,
    output logic              launch_o,
    output logic              launch_wr_o
);

    logic ctrl_wr;
    logic is_rd_cmd;
    logic is_wr_cmd;

    assign ctrl_wr   = cpu_sel && cpu_we && (cpu_addr == REG_CTRL);
    assign is_rd_cmd = (cpu_wdata == DATA_W'(CMD_READ));
    assign is_wr_cmd = (cpu_wdata == DATA_W'(CMD_WRITE));

    // doorbell only when idle and the command is valid
    assign launch_o    = ctrl_wr && !busy && (is_rd_cmd || is_wr_cmd);
    assign launch_wr_o = is_wr_cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_o   <= '0;
            maddr_o <= '0;
        end else if (cpu_sel && cpu_we) begin
            if (cpu_addr == REG_BLOCK) blk_o   <= cpu_wdata[BLK_W-1:0];
            if (cpu_addr == REG_MADDR) maddr_o <= cpu_wdata[ADDR_W-1:0];
        end
    end

    always_comb begin
        cpu_rdata = '0;
        unique case (cpu_addr)
            REG_STATUS: cpu_rdata[READY_BIT]    = !busy;
            REG_CTRL:   cpu_rdata               = '0;
            REG_BLOCK:  cpu_rdata[BLK_W-1:0]    = blk_o;
            REG_MADDR:  cpu_rdata[ADDR_W-1:0]   = maddr_o;
            default:    cpu_rdata               = '0;
        endcase
    end

endmodule

// File: rtl/blkdma_walker.sv
module blkdma_walker #(
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 16,
    parameter int WORDS  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [ADDR_W-1:0] maddr_i,
    output logic [BLK_W-1:0]  blk_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_o  <= '0;
            addr_o <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            blk_o  <= blk_i;
            addr_o <= maddr_i;
            cnt_q  <= '0;
        end else if (step) begin
            addr_o <= addr_o + ADDR_W'(1);
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    assign last_o = (cnt_q == CNT_W'(WORDS - 1));

endmodule

// File: rtl/blkdma_fsm.sv
module blkdma_fsm
    import blkdma_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_wr,
    input  logic              last,
    input  logic              sto_in_valid,
    input  logic              sto_out_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              step,
    output logic              sto_start,
    output logic              sto_dir,
    output logic              sto_in_ready,
    output logic              sto_out_valid,
    output logic [DATA_W-1:0] sto_out_data,
    output logic              mem_en,
    output logic              mem_we
);

    dma_state_e state_q, state_d;
    logic       dir_q;
    logic [DATA_W-1:0] hold_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            if (state_q == ST_IDLE && launch) dir_q  <= launch_wr;
            if (state_q == ST_WR_LATCH)       hold_q <= mem_rdata;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (launch) state_d = ST_ARM;
            ST_ARM:      state_d = dir_q ? ST_WR_FETCH : ST_RD_MOVE;
            ST_RD_MOVE:  if (sto_in_valid && last) state_d = ST_IDLE;
            ST_WR_FETCH: state_d = ST_WR_LATCH;
            ST_WR_LATCH: state_d = ST_WR_SEND;
            ST_WR_SEND:  if (sto_out_ready) state_d = last ? ST_IDLE : ST_WR_FETCH;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy          = 1'b1;
        step          = 1'b0;
        sto_start     = 1'b0;
        sto_in_ready  = 1'b0;
        sto_out_valid = 1'b0;
        mem_en        = 1'b0;
        mem_we        = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_ARM:      sto_start = 1'b1;
            ST_RD_MOVE: begin
                sto_in_ready = 1'b1;
                mem_en       = sto_in_valid;
                mem_we       = sto_in_valid;
                step         = sto_in_valid;
            end
            ST_WR_FETCH: mem_en = 1'b1;
            ST_WR_LATCH: ;
            ST_WR_SEND: begin
                sto_out_valid = 1'b1;
                step          = sto_out_ready;
            end
            default:     busy = 1'b0;
        endcase
    end

    assign sto_dir      = dir_q;
    assign sto_out_data = hold_q;

    p_hold_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_out_valid && !sto_out_ready) |=> (sto_out_valid && $stable(sto_out_data)));

    p_mem_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> !busy);

endmodule

// File: rtl/blkdma_engine.sv
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int BLK_W  = 16,
    parameter int WORDS  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [RA_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sto_start,
    output logic              sto_dir,
    output logic [BLK_W-1:0]  sto_blk,
    input  logic              sto_in_valid,
    output logic              sto_in_ready,
    input  logic [DATA_W-1:0] sto_in_data,
    output logic              sto_out_valid,
    input  logic              sto_out_ready,
    output logic [DATA_W-1:0] sto_out_data
);

    logic              busy;
    logic              launch;
    logic              launch_wr;
    logic              step;
    logic              last;
    logic [BLK_W-1:0]  blk_reg;
    logic [ADDR_W-1:0] maddr_reg;

    blkdma_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BLK_W(BLK_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_sel    (cpu_sel),
        .cpu_we     (cpu_we),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .busy       (busy),
        .blk_o      (blk_reg),
        .maddr_o    (maddr_reg),
        .launch_o   (launch),
        .launch_wr_o(launch_wr)
    );

    blkdma_walker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .WORDS(WORDS)) walk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (launch),
        .step   (step),
        .blk_i  (blk_reg),
        .maddr_i(maddr_reg),
        .blk_o  (sto_blk),
        .addr_o (mem_addr),
        .last_o (last)
    );

    blkdma_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_wr    (launch_wr),
        .last         (last),
        .sto_in_valid (sto_in_valid),
        .sto_out_ready(sto_out_ready),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .step         (step),
        .sto_start    (sto_start),
        .sto_dir      (sto_dir),
        .sto_in_ready (sto_in_ready),
        .sto_out_valid(sto_out_valid),
        .sto_out_data (sto_out_data),
        .mem_en       (mem_en),
        .mem_we       (mem_we)
    );

    assign mem_wdata = sto_in_data;

    p_doorbell_r3: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (busy && sto_start));

    p_no_relaunch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);

endmodule

// File: tb/blkdma_engine_tb_top.sv
module blkdma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_sel, cpu_we;
    logic [1:0]  cpu_addr;
    logic [15:0] cpu_wdata, cpu_rdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata;
    logic        sto_start, sto_dir;
    logic [15:0] sto_blk;
    logic        sto_in_valid, sto_in_ready;
    logic [15:0] sto_in_data;
    logic        sto_out_valid, sto_out_ready;
    logic [15:0] sto_out_data;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int bad_wr = 0;
    logic [15:0] mem_m [int];

    always #10 clk = ~clk;

    blkdma_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sto_start(sto_start), .sto_dir(sto_dir), .sto_blk(sto_blk),
        .sto_in_valid(sto_in_valid), .sto_in_ready(sto_in_ready), .sto_in_data(sto_in_data),
        .sto_out_valid(sto_out_valid), .sto_out_ready(sto_out_ready), .sto_out_data(sto_out_data)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (mem_en && mem_we) begin
            mem_m[int'(mem_addr)] = mem_wdata;
            wr_cnt++;
            if (!sto_in_valid) bad_wr++;
        end
        if (mem_en && !mem_we)
            mem_rdata <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 16'h0000;
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [15:0] d);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        cpu_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        @(negedge clk); #1;
        cpu_read(2'd0, d); chk("R1", "status after reset", d, 16'h8000);
        cpu_read(2'd1, d); chk("R2", "control reads zero", d, 16'h0000);
        cpu_read(2'd2, d); chk("R2", "block reset value", d, 16'h0000);
        cpu_read(2'd3, d); chk("R2", "address reset value", d, 16'h0000);
        chk("R1", "mem_en idle", mem_en, 1'b0);
        chk("R1", "sto_start idle", sto_start, 1'b0);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        cpu_write(2'd2, 16'hBEEF);
        cpu_write(2'd3, 16'h4321);
        #1;
        cpu_read(2'd2, d); chk("R2", "block readback", d, 16'hBEEF);
        cpu_read(2'd3, d); chk("R2", "address readback", d, 16'h4321);
        cpu_read(2'd0, d); chk("R1", "still ready", d, 16'h8000);
    endtask

    task automatic t_noop();
        logic [15:0] d;
        logic [15:0] vals [3] = '{16'h0000, 16'h0003, 16'h0101};
        foreach (vals[k]) begin
            cpu_write(2'd1, vals[k]);
            #1;
            chk("R7", "no start on invalid command", sto_start, 1'b0);
            cpu_read(2'd0, d); chk("R7", "ready after invalid command", d, 16'h8000);
            chk("R1", "no memory access", mem_en, 1'b0);
        end
    endtask

    task automatic t_read_xfer(input logic [15:0] blk, input logic [15:0] start,
                               input logic [15:0] seed, input bit gap, input bit poke);
        logic [15:0] d;
        int mism;
        int gap_bad;
        wr_cnt = 0; bad_wr = 0; gap_bad = 0;
        cpu_write(2'd2, blk);
        cpu_write(2'd3, start);
        cpu_write(2'd1, 16'h0001);
        #1;
        chk("R3", "start pulse", sto_start, 1'b1);
        chk("R3", "start direction", sto_dir, 1'b0);
        chk("R3", "start block", sto_blk, blk);
        cpu_read(2'd0, d); chk("R3", "ready low after doorbell", d, 16'h0000);
        for (int i = 0; i < 256; i++) begin
            if (gap && (i % 5 == 2)) begin
                @(negedge clk);
                sto_in_valid = 1'b0; cpu_sel = 1'b0;
                #1 if (mem_en) gap_bad++;
            end
            @(negedge clk);
            cpu_sel = 1'b0; cpu_we = 1'b0;
            if (i == 1) chk("R3", "start pulse is one cycle", sto_start, 1'b0);
            if (poke && i == 10) begin cpu_sel = 1; cpu_we = 1; cpu_addr = 2'd3; cpu_wdata = 16'h1234; end
            if (poke && i == 20) begin cpu_sel = 1; cpu_we = 1; cpu_addr = 2'd1; cpu_wdata = 16'h0002; end
            if (poke && i == 30) begin cpu_sel = 1; cpu_we = 1; cpu_addr = 2'd2; cpu_wdata = 16'h7777; end
            sto_in_valid = 1'b1;
            sto_in_data  = seed + 16'(i);
            #1;
            if (i == 255) begin
                cpu_read(2'd0, d); chk("R6", "ready low before final word", d, 16'h0000);
            end
        end
        @(negedge clk);
        sto_in_valid = 1'b0; cpu_sel = 1'b0; cpu_we = 1'b0;
        #1;
        cpu_read(2'd0, d); chk("R6", "ready after final word", d, 16'h8000);
        chk("R4", "memory write count", wr_cnt, 256);
        chk("R10", "writes without valid", bad_wr, 0);
        if (gap) chk("R10", "memory access in gap cycles", gap_bad, 0);
        mism = 0;
        for (int i = 0; i < 256; i++) begin
            int a;
            a = int'(16'(start + 16'(i)));
            if (!mem_m.exists(a) || mem_m[a] !== seed + 16'(i)) mism++;
        end
        chk(start > 16'hFF00 ? "R8" : "R4", "mismatched memory words", mism, 0);
        if (poke) begin
            cpu_read(2'd3, d); chk("R9", "address register readback", d, 16'h1234);
            cpu_read(2'd2, d); chk("R9", "block register readback", d, 16'h7777);
            chk("R7", "busy control write ignored, no start", sto_start, 1'b0);
        end
    endtask

    task automatic t_write_xfer(input logic [15:0] blk, input logic [15:0] start, input bit stall);
        logic [15:0] d;
        logic [15:0] held;
        int got, bad, guard, hold_bad;
        bit was_stalled;
        bit rdy;
        for (int i = 0; i < 256; i++)
            mem_m[int'(16'(start + 16'(i)))] = 16'hA5A5 ^ 16'(i * 16'h0107);
        wr_cnt = 0;
        cpu_write(2'd2, blk);
        cpu_write(2'd3, start);
        cpu_write(2'd1, 16'h0002);
        #1;
        chk("R5", "start pulse", sto_start, 1'b1);
        chk("R5", "start direction", sto_dir, 1'b1);
        chk("R5", "start block", sto_blk, blk);
        got = 0; bad = 0; guard = 0; hold_bad = 0; was_stalled = 0; held = '0;
        while (got < 256 && guard < 5000) begin
            @(negedge clk);
            guard++;
            rdy = !(stall && (guard % 4 == 0));
            sto_out_ready = rdy;
            #1;
            if (was_stalled && (!sto_out_valid || sto_out_data !== held)) hold_bad++;
            was_stalled = sto_out_valid && !rdy;
            held = sto_out_data;
            if (sto_out_valid && rdy) begin
                if (sto_out_data !== (16'hA5A5 ^ 16'(got * 16'h0107))) bad++;
                if (got == 255) begin
                    cpu_read(2'd0, d); chk("R6", "ready low before final word", d, 16'h0000);
                end
                got++;
            end
        end
        @(negedge clk);
        sto_out_ready = 1'b0;
        #1;
        cpu_read(2'd0, d); chk("R6", "ready after final word", d, 16'h8000);
        chk("R5", "words sent", got, 256);
        chk(start > 16'hFF00 ? "R8" : "R11", "mismatched outgoing words", bad, 0);
        chk("R11", "no memory writes in write transfer", wr_cnt, 0);
        if (stall) chk("R10", "stalled word not held", hold_bad, 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (R1..R11 run): actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        cpu_sel = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
        sto_in_valid = 0; sto_in_data = 0; sto_out_ready = 0;
        mem_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_noop();
        t_read_xfer(16'h0005, 16'h0100, 16'h3000, 1'b0, 1'b1);
        t_read_xfer(16'hFFFF, 16'hFF80, 16'h5A00, 1'b1, 1'b0);
        t_write_xfer(16'h0042, 16'h2000, 1'b1);
        t_write_xfer(16'h0009, 16'hFFF0, 1'b0);
        finish_run();
    end

endmodule